// File: doc/BRIEF.md
# One-Time-Programmable Wiper Store Sequencer

This block keeps a small non-volatile bank of wiper settings. The bank can be programmed a limited number of times, and each program operation writes a fresh slot. Store, refresh and memory-read requests come from the command controller. A store starts a timed programming window of several milliseconds. For that whole window the block holds a busy lock toward the serial shift register and drives its ready line low. Ready returns high when the window ends. The window length is set by a cycle counter, parameterised by clock frequency in MHz and window length in microseconds.

The block has three states. `SEQ_BOOT` runs once after reset and performs the power-up restore. `SEQ_IDLE` accepts requests. `SEQ_PROG` times a programming window. The transitions are:
- BOOT→IDLE always, after one cycle.
- IDLE→PROG on an accepted store.
- PROG→IDLE when the programming timer expires, which is also when the slot is committed.

Restore and refresh each complete in one cycle and never raise the lock. When the bank is empty, a restore loads the midscale code. The slot bank is modelled as registers, and the power-on reset `rst_n` represents a fresh, unprogrammed part.

Top module: `otp_store_seq`

## Requirements
- R1: While `rst_n` is low, `busy_lock`=0, `ready`=1, `wiper_load`=0 and `rd_data`=0. After reset the slot count and the full flag are both zero.
- R2: In the first cycle after reset is released, `wiper_load` pulses for one cycle with `wiper_value` equal to the latest stored value. With nothing stored, that value is midscale, 2^(DATA_W-1) (512 for 10 bits).
- R3: A store request accepted in idle raises `busy_lock` and drops `ready` in the next cycle. Both hold for exactly CLK_MHZ*STORE_US cycles and then return to `busy_lock`=0, `ready`=1.
- R4: Each completed store writes `store_data` into a new slot and increments the slot count by one at the end of the window. The count never exceeds SLOTS (20).
- R5: Store, refresh and read requests made while the lock is held are ignored. No window is extended or restarted, no load pulse occurs, and `rd_data` is unchanged.
- R6: A refresh request in idle produces a one-cycle `wiper_load` pulse in the next cycle, with the latest stored value (or midscale when empty). A refresh never raises `busy_lock`.
- R7: A read request in idle updates `rd_data` in the next cycle and holds it until the next accepted read. With `read_status`=0 the result is the latest stored value (midscale when empty). With `read_status`=1 the result is the status word: bits [4:0] hold the slot count, bit 5 holds the full flag, and the upper bits are zero.
- R8: A store requested when all SLOTS slots are used does not raise the lock and leaves the count unchanged. It sets the full flag, which then stays set until reset.
- R9: When several requests arrive in the same idle cycle, store wins over refresh and refresh wins over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| store_req | input | 1 | Request to program the next slot |
| store_data | input | DATA_W | Wiper code to program |
| refresh_req | input | 1 | Request to reload the wiper from the bank |
| read_req | input | 1 | Request to read the bank |
| read_status | input | 1 | 1 selects the status word, 0 the latest value |
| busy_lock | output | 1 | Lock on the serial shift register during programming |
| ready | output | 1 | Low while programming, high otherwise |
| wiper_load | output | 1 | One-cycle strobe to load the wiper register |
| wiper_value | output | DATA_W | Value to load into the wiper register |
| rd_data | output | DATA_W | Result of the last accepted read |

## Verification
The hardest state to reach is the exhausted bank. Getting there takes twenty complete programming windows, and with the default timing each window lasts millions of cycles. The bench sets STORE_US to 1, which gives a 250-cycle window. It then chains twenty stores, each issued as soon as ready returns, and follows them with a twenty-first store and a status read. Requests are also fired in the middle of a window, and all three requests are raised in one idle cycle, to exercise the lock and the priority order.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_BOOT = 2'd0,
        SEQ_IDLE = 2'd1,
        SEQ_PROG = 2'd2
    } seq_state_e;
endpackage

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
    parameter int CYCLES = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int TMR_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(CYCLES - 1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LAST;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/otp_slot_bank.sv
module otp_slot_bank #(
    parameter int DATA_W = 10,
    parameter int SLOTS  = 20,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  used_cnt,
    output logic              is_full,
    output logic [DATA_W-1:0] latest
);
    localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  slot_we;

    assign is_full = (used_cnt == CNT_W'(SLOTS));

    for (genvar g = 0; g < SLOTS; g++) begin : g_we
        assign slot_we[g] = wr_en && (used_cnt == CNT_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (slot_we[i]) slot_q[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_cnt <= '0;
        end else if (wr_en && !is_full) begin
            used_cnt <= used_cnt + 1'b1;
        end
    end

    always_comb begin
        latest = MIDSCALE;
        for (int i = 0; i < SLOTS; i++) begin
            if (used_cnt == CNT_W'(i + 1)) latest = slot_q[i];
        end
    end
endmodule

// File: rtl/otp_store_seq.sv
module otp_store_seq
    import otp_seq_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SLOTS    = 20,
    parameter int CLK_MHZ  = 250,
    parameter int STORE_US = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic [DATA_W-1:0] store_data,
    input  logic              refresh_req,
    input  logic              read_req,
    input  logic              read_status,
    output logic              busy_lock,
    output logic              ready,
    output logic              wiper_load,
    output logic [DATA_W-1:0] wiper_value,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PROG_CYCLES = CLK_MHZ * STORE_US;
    localparam int CNT_W       = $clog2(SLOTS + 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  used_cnt;
    logic              bank_full;
    logic [DATA_W-1:0] latest;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] status_word;
    logic              full_q;
    logic              accept_store;
    logic              commit;
    logic              tmr_done;

    assign accept_store = (state_q == SEQ_IDLE) && store_req && !bank_full;
    assign commit       = (state_q == SEQ_PROG) && tmr_done;
    assign status_word  = DATA_W'({full_q, used_cnt});

    otp_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept_store),
        .run   (state_q == SEQ_PROG),
        .done  (tmr_done)
    );

    otp_slot_bank #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .wr_data  (pend_q),
        .used_cnt (used_cnt),
        .is_full  (bank_full),
        .latest   (latest)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_BOOT: state_d = SEQ_IDLE;
            SEQ_IDLE: if (accept_store) state_d = SEQ_PROG;
            SEQ_PROG: if (tmr_done) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q <= '0;
        else if (accept_store) pend_q <= store_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_lock   <= 1'b0;
            ready       <= 1'b1;
            wiper_load  <= 1'b0;
            wiper_value <= '0;
            rd_data     <= '0;
            full_q      <= 1'b0;
        end else begin
            wiper_load <= 1'b0;
            unique case (state_q)
                SEQ_BOOT: begin
                    wiper_load  <= 1'b1;
                    wiper_value <= latest;
                end
                SEQ_IDLE: begin
                    if (store_req) begin
                        if (bank_full) begin
                            full_q <= 1'b1;
                        end else begin
                            busy_lock <= 1'b1;
                            ready     <= 1'b0;
                        end
                    end else if (refresh_req) begin
                        wiper_load  <= 1'b1;
                        wiper_value <= latest;
                    end else if (read_req) begin
                        rd_data <= read_status ? status_word : latest;
                    end
                end
                SEQ_PROG: begin
                    if (tmr_done) begin
                        busy_lock <= 1'b0;
                        ready     <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/otp_store_seq_chk.sv
module otp_store_seq_chk #(
    parameter int PROG_CYCLES = 1500000,
    parameter int SLOTS       = 20,
    parameter int CNT_W       = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_lock,
    input logic             ready,
    input logic             wiper_load,
    input logic [CNT_W-1:0] used_cnt,
    input logic             full_flag
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= 0;
        else if (busy_lock) run_len <= run_len + 1;
        else                run_len <= 0;
    end

    p_lock_vs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_lock |-> !ready);

    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_lock) |-> run_len == PROG_CYCLES);

    p_slot_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_lock) |-> used_cnt == $past(used_cnt) + 1'b1);

    p_count_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(used_cnt) |-> $fell(busy_lock));

    p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= CNT_W'(SLOTS));

    p_no_load_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wiper_load |-> !busy_lock);

    p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |=> full_flag);
endmodule

bind otp_store_seq otp_store_seq_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .SLOTS       (SLOTS),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_lock  (busy_lock),
    .ready      (ready),
    .wiper_load (wiper_load),
    .used_cnt   (used_cnt),
    .full_flag  (full_q)
);

// File: tb/otp_store_seq_test.sv
module otp_store_seq_test;
    localparam int DATA_W = 10;
    localparam int SLOTS  = 20;
    localparam int N_WIN  = 250;
    localparam int MID    = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic store_req = 1'b0, refresh_req = 1'b0, read_req = 1'b0, read_status = 1'b0;
    logic [DATA_W-1:0] store_data = '0;
    logic busy_lock, ready, wiper_load;
    logic [DATA_W-1:0] wiper_value, rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    otp_store_seq #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CLK_MHZ(250), .STORE_US(1)) uut (
        .clk(clk), .rst_n(rst_n), .store_req(store_req), .store_data(store_data),
        .refresh_req(refresh_req), .read_req(read_req), .read_status(read_status),
        .busy_lock(busy_lock), .ready(ready), .wiper_load(wiper_load),
        .wiper_value(wiper_value), .rd_data(rd_data)
    );

    // behavioural reference
    int q[$];
    bit m_boot, m_busy, m_ready, m_load, m_full;
    int m_timer, m_pend, m_val, m_rd;

    function automatic int restore_val();
        return (q.size() == 0) ? MID : q[$];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_boot = 1; m_busy = 0; m_ready = 1; m_load = 0; m_full = 0;
            m_timer = 0; m_pend = 0; m_val = 0; m_rd = 0;
        end else begin
            m_load = 0;
            if (m_boot) begin
                m_load = 1; m_val = restore_val(); m_boot = 0;
            end else if (m_busy) begin
                m_timer--;
                if (m_timer == 0) begin
                    q.push_back(m_pend); m_busy = 0; m_ready = 1;
                end
            end else if (store_req) begin
                if (q.size() < SLOTS) begin
                    m_busy = 1; m_ready = 0; m_pend = int'(store_data); m_timer = N_WIN;
                end else m_full = 1;
            end else if (refresh_req) begin
                m_load = 1; m_val = restore_val();
            end else if (read_req) begin
                m_rd = read_status ? ((int'(m_full) << 5) | q.size()) : restore_val();
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy_lock, m_busy, "R3 busy_lock");
            chk(ready, m_ready, "R3 ready");
            chk(wiper_load, m_load, "R6 wiper_load");
            if (m_load) chk(wiper_value, m_val, "R6 wiper_value");
            chk(rd_data, m_rd, "R7 rd_data");
        end
    end

    task automatic drive(input bit st, input int d, input bit rf, input bit rd, input bit rs);
        @(negedge clk);
        store_req = st; store_data = DATA_W'(d); refresh_req = rf; read_req = rd; read_status = rs;
        @(negedge clk);
        store_req = 0; refresh_req = 0; read_req = 0; read_status = 0;
    endtask

    task automatic wait_idle();
        while (busy_lock) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy_lock, 0, "R1 busy in reset");
        chk(ready, 1, "R1 ready in reset");
        chk(wiper_load, 0, "R1 load in reset");
        chk(rd_data, 0, "R1 rd_data in reset");
        rst_n = 1;
        @(negedge clk);
        chk(wiper_load, 1, "R2 power-up load");
        chk(wiper_value, MID, "R2 power-up midscale");
        drive(0, 0, 0, 1, 1); chk(rd_data, 0, "R7 empty status");
        drive(0, 0, 0, 1, 0); chk(rd_data, MID, "R7 empty contents");
        drive(0, 0, 1, 0, 0); chk(wiper_value, MID, "R6 refresh empty");
        chk(busy_lock, 0, "R6 refresh no lock");
        // store, then poke during the window
        drive(1, 341, 0, 0, 0);
        chk(busy_lock, 1, "R3 lock after store");
        drive(0, 0, 1, 0, 0); chk(wiper_load, 0, "R5 refresh while locked");
        drive(0, 0, 0, 1, 1); chk(rd_data, MID, "R5 read while locked");
        drive(1, 7, 0, 0, 0);
        wait_idle();
        drive(0, 0, 0, 1, 1); chk(rd_data, 1, "R4 count after one store");
        drive(0, 0, 0, 1, 0); chk(rd_data, 341, "R5 late store not written");
        // simultaneous requests: store wins
        drive(1, 100, 1, 1, 0);
        chk(busy_lock, 1, "R9 store wins lock");
        chk(wiper_load, 0, "R9 no refresh");
        wait_idle();
        drive(0, 0, 1, 1, 1); chk(wiper_value, 100, "R9 refresh beats read");
        chk(rd_data, 341, "R9 read dropped");
        // fill the bank
        for (int i = 2; i < SLOTS; i++) begin
            drive(1, 600 + i, 0, 0, 0);
            wait_idle();
        end
        drive(0, 0, 0, 1, 1); chk(rd_data, 20, "R4 count at twenty");
        drive(1, 55, 0, 0, 0);
        chk(busy_lock, 0, "R8 no lock when full");
        drive(0, 0, 0, 1, 1); chk(rd_data, 32 + 20, "R8 full flag in status");
        drive(0, 0, 1, 0, 0); chk(wiper_value, 619, "R6 refresh latest");
        drive(0, 0, 0, 1, 1); chk(rd_data, 52, "R8 full flag sticky");
        // power cycle
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(rd_data, 0, "R1 rd_data cleared");
        rst_n = 1;
        @(negedge clk);
        chk(wiper_value, MID, "R2 restore after reset");
        drive(0, 0, 0, 1, 1); chk(rd_data, 0, "R1 count and flag cleared");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule